// File: doc/BRIEF.md
# Congestion Xoff/Xon Flow Gate

This block decides, for every outgoing packet, whether its flow may be sent while the switch fabric reports congestion. A flow is the pair of a destination ID and a priority. Congestion notifications from the fabric (packet type 7) reach the block already decoded, as one event per cycle: an Xoff or an Xon command with a flow key. The block never acknowledges these events and never waits for one, because the fabric neither expects a reply nor guarantees delivery.

A small associative table holds one Xoff counter per congested flow. The first Xoff for a flow claims a free entry. Later Xoffs raise the count and each Xon lowers it. When the count returns to zero the entry is released and the flow is open again. Two query ports, one for direct load/store traffic and one for descriptor-driven DMA traffic, each present a flow key and get a combinational block/allow answer taken from the registered table. Checking a packet therefore costs no clock cycle.

Top module: `xoff_flow_gate`

## Requirements
- R1: After reset every flow is allowed on both query ports and the overflow flag reads 0.
- R2: An accepted Xoff for a flow makes queries carrying that exact destination ID and priority report block, starting in the cycle after the event.
- R3: Only an exact match of both destination ID and priority is blocked: the same destination with another priority, or another destination with the same priority, stays allowed.
- R4: Xoffs for one flow accumulate, and the flow is released only after as many Xons as Xoffs have arrived. After N Xoffs and N-1 Xons it is still blocked.
- R5: An Xon for a flow with no table entry (zero count) is ignored. It opens nothing, claims no entry, and does not make the next Xoff for that flow count less.
- R6: An entry whose count returns to zero is freed, so a later Xoff for a new flow is accepted in that slot even though the table was full before.
- R7: An Xoff for a new flow while all ENTRIES slots hold nonzero counts is dropped (that flow stays allowed) and sets the overflow output to 1. The flag stays 1 until reset.
- R8: A flow's count saturates at 2^CNT_W-1 (15 with the default CNT_W=4). Further Xoffs leave it there, so with the defaults, 17 Xoffs followed by 14 Xons still block, and the 15th Xon releases the flow.
- R9: The block/allow outputs depend combinationally on the query inputs and the registered table: a changed query is answered without a clock edge, and an event takes effect only at the next edge.
- R10: The two query ports are served independently and at the same time. Each reports its own flow's state, and equal keys give equal answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | A congestion event is presented this cycle |
| ev_xoff | input | 1 | 1 = Xoff (close flow), 0 = Xon (open flow) |
| ev_dest | input | DEST_W | Destination ID of the event's flow |
| ev_prio | input | PRIO_W | Priority of the event's flow |
| ls_dest | input | DEST_W | Destination ID of the load/store packet being checked |
| ls_prio | input | PRIO_W | Priority of the load/store packet being checked |
| ls_block | output | 1 | 1 = load/store packet must be held |
| dma_dest | input | DEST_W | Destination ID of the DMA packet being checked |
| dma_prio | input | PRIO_W | Priority of the DMA packet being checked |
| dma_block | output | 1 | 1 = DMA packet must be held |
| overflow | output | 1 | Sticky: an Xoff was dropped because the table was full |

## Verification
A congestion event and a query for the same flow can arrive in the same cycle. The bench provokes this by presenting an Xoff and, before the clock edge, querying that flow on both ports. It expects allow in that cycle and block after the edge, which confirms that queries read the registered table rather than the pending update. The full-table case also places a dropped Xoff next to a query of the dropped flow and expects allow together with a raised overflow flag.

// File: rtl/xfg_pkg.sv
package xfg_pkg;
    typedef enum logic {
        OP_XON  = 1'b0,
        OP_XOFF = 1'b1
    } cc_op_e;
endpackage

// File: rtl/xfg_match.sv
module xfg_match #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 18,
    parameter int CNT_W   = 4
) (
    input  logic [ENTRIES-1:0][KEY_W-1:0] keys,
    input  logic [ENTRIES-1:0][CNT_W-1:0] cnts,
    input  logic [KEY_W-1:0]              probe,
    output logic [ENTRIES-1:0]            hit
);
    // An entry is live exactly when its count is nonzero.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit[i] = (cnts[i] != '0) && (keys[i] == probe);
    end
endmodule

// File: rtl/xfg_lookup.sv
module xfg_lookup #(
    parameter int ENTRIES = 8,
    parameter int DEST_W  = 16,
    parameter int PRIO_W  = 2,
    parameter int CNT_W   = 4,
    localparam int KEY_W  = DEST_W + PRIO_W
) (
    input  logic [ENTRIES-1:0][KEY_W-1:0] keys,
    input  logic [ENTRIES-1:0][CNT_W-1:0] cnts,
    input  logic [DEST_W-1:0]             q_dest,
    input  logic [PRIO_W-1:0]             q_prio,
    output logic                          blocked
);
    logic [ENTRIES-1:0] hit;

    xfg_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .CNT_W(CNT_W)) u_match (
        .keys  (keys),
        .cnts  (cnts),
        .probe ({q_dest, q_prio}),
        .hit   (hit)
    );

    assign blocked = |hit;
endmodule

// File: rtl/xfg_table.sv
module xfg_table #(
    parameter int ENTRIES = 8,
    parameter int DEST_W  = 16,
    parameter int PRIO_W  = 2,
    parameter int CNT_W   = 4,
    localparam int KEY_W  = DEST_W + PRIO_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ev_valid,
    input  logic                          ev_xoff,
    input  logic [DEST_W-1:0]             ev_dest,
    input  logic [PRIO_W-1:0]             ev_prio,
    output logic [ENTRIES-1:0][KEY_W-1:0] keys,
    output logic [ENTRIES-1:0][CNT_W-1:0] cnts,
    output logic                          overflow,
    output logic                          xoff_drop
);
    import xfg_pkg::*;

    typedef struct packed {
        logic [ENTRIES-1:0][KEY_W-1:0] key;
        logic [ENTRIES-1:0][CNT_W-1:0] cnt;
        logic                          ovf;
    } tbl_t;

    tbl_t               tbl_d, tbl_q;
    logic [ENTRIES-1:0] ev_hit;
    logic [KEY_W-1:0]   ev_key;
    logic [IDX_W-1:0]   free_idx;
    logic               free_any;
    cc_op_e             op;

    assign ev_key = {ev_dest, ev_prio};
    assign op     = cc_op_e'(ev_xoff);

    xfg_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .CNT_W(CNT_W)) u_ev_match (
        .keys  (tbl_q.key),
        .cnts  (tbl_q.cnt),
        .probe (ev_key),
        .hit   (ev_hit)
    );

    // Lowest-numbered empty slot.
    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (tbl_q.cnt[i] == '0) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    always_comb begin
        tbl_d     = tbl_q;
        xoff_drop = 1'b0;
        if (ev_valid) begin
            if (op == OP_XOFF) begin
                if (|ev_hit) begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        if (ev_hit[i] && tbl_q.cnt[i] != CNT_MAX) begin
                            tbl_d.cnt[i] = tbl_q.cnt[i] + 1'b1;
                        end
                    end
                end else if (free_any) begin
                    tbl_d.key[free_idx] = ev_key;
                    tbl_d.cnt[free_idx] = CNT_W'(1);
                end else begin
                    tbl_d.ovf = 1'b1;
                    xoff_drop = 1'b1;
                end
            end else begin
                // A hit implies a nonzero count; a miss is ignored.
                for (int i = 0; i < ENTRIES; i++) begin
                    if (ev_hit[i]) begin
                        tbl_d.cnt[i] = tbl_q.cnt[i] - 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign keys     = tbl_q.key;
    assign cnts     = tbl_q.cnt;
    assign overflow = tbl_q.ovf;
endmodule

// File: rtl/xoff_flow_gate.sv
module xoff_flow_gate #(
    parameter int ENTRIES = 8,
    parameter int DEST_W  = 16,
    parameter int PRIO_W  = 2,
    parameter int CNT_W   = 4,
    localparam int KEY_W  = DEST_W + PRIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_xoff,
    input  logic [DEST_W-1:0] ev_dest,
    input  logic [PRIO_W-1:0] ev_prio,
    input  logic [DEST_W-1:0] ls_dest,
    input  logic [PRIO_W-1:0] ls_prio,
    output logic              ls_block,
    input  logic [DEST_W-1:0] dma_dest,
    input  logic [PRIO_W-1:0] dma_prio,
    output logic              dma_block,
    output logic              overflow
);
    logic [ENTRIES-1:0][KEY_W-1:0] keys;
    logic [ENTRIES-1:0][CNT_W-1:0] cnts;
    logic                          xoff_drop;

    xfg_table #(.ENTRIES(ENTRIES), .DEST_W(DEST_W), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .ev_xoff   (ev_xoff),
        .ev_dest   (ev_dest),
        .ev_prio   (ev_prio),
        .keys      (keys),
        .cnts      (cnts),
        .overflow  (overflow),
        .xoff_drop (xoff_drop)
    );

    xfg_lookup #(.ENTRIES(ENTRIES), .DEST_W(DEST_W), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_ls_gate (
        .keys    (keys),
        .cnts    (cnts),
        .q_dest  (ls_dest),
        .q_prio  (ls_prio),
        .blocked (ls_block)
    );

    xfg_lookup #(.ENTRIES(ENTRIES), .DEST_W(DEST_W), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_dma_gate (
        .keys    (keys),
        .cnts    (cnts),
        .q_dest  (dma_dest),
        .q_prio  (dma_prio),
        .blocked (dma_block)
    );
endmodule

// File: rtl/xfg_checker.sv
module xfg_checker #(
    parameter int DEST_W = 16,
    parameter int PRIO_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              ev_xoff,
    input logic [DEST_W-1:0] ev_dest,
    input logic [PRIO_W-1:0] ev_prio,
    input logic [DEST_W-1:0] ls_dest,
    input logic [PRIO_W-1:0] ls_prio,
    input logic              ls_block,
    input logic [DEST_W-1:0] dma_dest,
    input logic [PRIO_W-1:0] dma_prio,
    input logic              dma_block,
    input logic              overflow,
    input logic              xoff_drop
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !overflow);

    // R2
    xoff_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_xoff && !xoff_drop && ({ev_dest, ev_prio} == {ls_dest, ls_prio}))
        |=> (!($stable(ls_dest) && $stable(ls_prio)) || ls_block));

    // R5
    xon_never_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_xoff && !ls_block)
        |=> (!($stable(ls_dest) && $stable(ls_prio)) || !ls_block));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R7
    drop_raises_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_drop |=> overflow);

    // R9
    quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> (!($stable(ls_dest) && $stable(ls_prio)) || $stable(ls_block)));

    // R10
    ports_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({ls_dest, ls_prio} == {dma_dest, dma_prio}) |-> (ls_block == dma_block));
endmodule

bind xoff_flow_gate xfg_checker #(.DEST_W(DEST_W), .PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_xoff   (ev_xoff),
    .ev_dest   (ev_dest),
    .ev_prio   (ev_prio),
    .ls_dest   (ls_dest),
    .ls_prio   (ls_prio),
    .ls_block  (ls_block),
    .dma_dest  (dma_dest),
    .dma_prio  (dma_prio),
    .dma_block (dma_block),
    .overflow  (overflow),
    .xoff_drop (xoff_drop)
);

// File: tb/xoff_flow_gate_test.sv
module xoff_flow_gate_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEST_W     = 16;
    localparam int PRIO_W     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_valid = 1'b0;
    logic              ev_xoff = 1'b0;
    logic [DEST_W-1:0] ev_dest = '0;
    logic [PRIO_W-1:0] ev_prio = '0;
    logic [DEST_W-1:0] ls_dest = '0;
    logic [PRIO_W-1:0] ls_prio = '0;
    logic [DEST_W-1:0] dma_dest = '0;
    logic [PRIO_W-1:0] dma_prio = '0;
    logic              ls_block, dma_block, overflow;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xoff_flow_gate uut (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_xoff(ev_xoff), .ev_dest(ev_dest), .ev_prio(ev_prio),
        .ls_dest(ls_dest), .ls_prio(ls_prio), .ls_block(ls_block),
        .dma_dest(dma_dest), .dma_prio(dma_prio), .dma_block(dma_block),
        .overflow(overflow)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    // One event, registered at the posedge between two negedges.
    task automatic send(input logic xoff, input logic [DEST_W-1:0] d, input logic [PRIO_W-1:0] p);
        ev_valid = 1'b1; ev_xoff = xoff; ev_dest = d; ev_prio = p;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic query(input logic [DEST_W-1:0] d, input logic [PRIO_W-1:0] p);
        ls_dest = d; ls_prio = p; dma_dest = d; dma_prio = p;
        #1;
    endtask

    task automatic t_reset;
        query(16'h0000, 2'd0);
        check(ls_block, 1'b0, "R1", "ls after reset");
        check(dma_block, 1'b0, "R1", "dma after reset");
        check(overflow, 1'b0, "R1", "overflow after reset");
        query(16'hBEEF, 2'd3);
        check(ls_block, 1'b0, "R1", "other flow after reset");
    endtask

    task automatic t_basic_key;
        send(1'b1, 16'h1234, 2'd1);
        query(16'h1234, 2'd1);
        check(ls_block, 1'b1, "R2", "ls blocked after xoff");
        check(dma_block, 1'b1, "R2", "dma blocked after xoff");
        query(16'h1234, 2'd2);
        check(ls_block, 1'b0, "R3", "same dest other prio");
        query(16'h1235, 2'd1);
        check(ls_block, 1'b0, "R3", "other dest same prio");
        send(1'b0, 16'h1234, 2'd1);
        query(16'h1234, 2'd1);
        check(ls_block, 1'b0, "R4", "one xon releases one xoff");
    endtask

    task automatic t_same_cycle;
        ev_valid = 1'b1; ev_xoff = 1'b1; ev_dest = 16'h0A0A; ev_prio = 2'd0;
        query(16'h0A0A, 2'd0);
        check(ls_block, 1'b0, "R9", "event not yet applied before edge");
        @(negedge clk);
        ev_valid = 1'b0;
        #1;
        check(ls_block, 1'b1, "R9", "event applied after edge");
        // query switched with no edge in between
        ls_dest = 16'h0B0B; #1;
        check(ls_block, 1'b0, "R9", "query change answered without clock");
        ls_dest = 16'h0A0A; #1;
        check(ls_block, 1'b1, "R9", "query change back answered without clock");
        // two ports, two flows, same cycle
        ls_dest = 16'h0A0A; ls_prio = 2'd0; dma_dest = 16'h0C0C; dma_prio = 2'd0; #1;
        check(ls_block, 1'b1, "R10", "ls on closed flow");
        check(dma_block, 1'b0, "R10", "dma on open flow");
        send(1'b0, 16'h0A0A, 2'd0);
        query(16'h0A0A, 2'd0);
        check(ls_block, 1'b0, "R10", "cleanup release");
    endtask

    task automatic t_accum;
        for (int i = 0; i < 3; i++) send(1'b1, 16'h2222, 2'd3);
        send(1'b0, 16'h2222, 2'd3);
        send(1'b0, 16'h2222, 2'd3);
        query(16'h2222, 2'd3);
        check(ls_block, 1'b1, "R4", "3 xoff 2 xon still blocked");
        send(1'b0, 16'h2222, 2'd3);
        query(16'h2222, 2'd3);
        check(ls_block, 1'b0, "R4", "3 xoff 3 xon open");
    endtask

    task automatic t_xon_unknown;
        send(1'b0, 16'h3333, 2'd2);
        query(16'h3333, 2'd2);
        check(ls_block, 1'b0, "R5", "xon on unknown flow");
        send(1'b1, 16'h3333, 2'd2);
        send(1'b1, 16'h3333, 2'd2);
        send(1'b0, 16'h3333, 2'd2);
        query(16'h3333, 2'd2);
        check(ls_block, 1'b1, "R5", "earlier stray xon not credited");
        send(1'b0, 16'h3333, 2'd2);
        query(16'h3333, 2'd2);
        check(ls_block, 1'b0, "R5", "cleanup release");
        check(overflow, 1'b0, "R5", "no overflow from stray xon");
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 17; i++) send(1'b1, 16'h4444, 2'd0);
        query(16'h4444, 2'd0);
        check(ls_block, 1'b1, "R8", "17 xoffs do not wrap to open");
        for (int i = 0; i < 14; i++) send(1'b0, 16'h4444, 2'd0);
        query(16'h4444, 2'd0);
        check(ls_block, 1'b1, "R8", "14 xons after saturation still blocked");
        send(1'b0, 16'h4444, 2'd0);
        query(16'h4444, 2'd0);
        check(ls_block, 1'b0, "R8", "15th xon opens saturated flow");
    endtask

    task automatic t_full;
        for (int i = 0; i < 8; i++) send(1'b1, 16'h5000 + 16'(i), 2'd1);
        query(16'h5007, 2'd1);
        check(ls_block, 1'b1, "R7", "eighth flow held");
        check(overflow, 1'b0, "R7", "no overflow at exactly full");
        send(1'b1, 16'h6000, 2'd1);
        query(16'h6000, 2'd1);
        check(ls_block, 1'b0, "R7", "dropped xoff leaves flow open");
        check(overflow, 1'b1, "R7", "overflow set on drop");
        send(1'b0, 16'h7000, 2'd1);
        query(16'h5000, 2'd1);
        check(ls_block, 1'b1, "R5", "stray xon on full table changes nothing");
        send(1'b0, 16'h5003, 2'd1);
        query(16'h5003, 2'd1);
        check(ls_block, 1'b0, "R6", "released flow open");
        send(1'b1, 16'h6000, 2'd1);
        query(16'h6000, 2'd1);
        check(ls_block, 1'b1, "R6", "freed slot reused");
        check(overflow, 1'b1, "R7", "overflow sticky");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(overflow, 1'b0, "R1", "overflow cleared by reset");
        query(16'h6000, 2'd1);
        check(ls_block, 1'b0, "R1", "table cleared by reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_key();
        t_same_cycle();
        t_accum();
        t_xon_unknown();
        t_saturate();
        t_full();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule